// File: doc/BRIEF.md
# Buffer Increment Engine

This block is a memory-side accelerator that rewrites a fixed-size buffer of signed 32-bit words in place. Software programs a byte base address into a control register over an AXI4-Lite slave port and then sets a start bit. The engine fetches every word of the buffer through an AXI4 master read channel into an internal word store. It then adds a fixed constant to each stored word and writes the results back to the addresses they came from through the AXI4 master write channel.

The buffer length (50 words), the constant (100) and the longest burst (16 beats) are parameters. Transfers use incrementing bursts of full-width words. A status word at the control offset reports whether the engine is idle and whether a pass has finished since the status was last read. The addition wraps modulo 2^32.

Top module: `incr_engine`

## Requirements
- R1: Offset 0x10 holds the byte base address and reads back the last value written to it. Offset 0x00 is the control and status word. A read of any other offset returns 0.
- R2: After reset the control word reads 0x4 (start 0, done 0, idle 1) and the base register reads 0. The master asserts no arvalid, awvalid or wvalid until a pass is started.
- R3: Writing a word with bit 0 set to offset 0x00 while the engine is idle starts one pass. Bit 0 reads back as 0 once the engine has left idle. Bit 2 (idle) reads 0 throughout the pass.
- R4: One pass replaces each of the 50 words from the base address upward with its old value plus 100, modulo 2^32, at the same address. Words just below and just above the buffer are left unchanged.
- R5: All 50 read beats of a pass are taken before the first write address is issued.
- R6: Each burst carries at most 16 beats, and arlen/awlen equal the beat count minus one. Bursts go to increasing addresses, each starting where the previous one ended. For 50 words the read bursts and the write bursts each have 16, 16, 16 and 2 beats, at the base plus 0, 64, 128 and 192 bytes. wlast is high on exactly the last beat of each write burst.
- R7: Bit 1 (done) of the control word becomes 1 when a pass completes. The read that returns it as 1 clears it, so the next read shows 0.
- R8: A start written while a pass is running has no effect. Exactly one pass of read and write bursts takes place, and each word is incremented only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | CTRL_AW | Control write address |
| s_awvalid | input | 1 | Control write address valid |
| s_awready | output | 1 | Control write address ready |
| s_wdata | input | DATA_W | Control write data |
| s_wvalid | input | 1 | Control write data valid |
| s_wready | output | 1 | Control write data ready |
| s_bvalid | output | 1 | Control write response valid |
| s_bready | input | 1 | Control write response ready |
| s_araddr | input | CTRL_AW | Control read address |
| s_arvalid | input | 1 | Control read address valid |
| s_arready | output | 1 | Control read address ready |
| s_rdata | output | DATA_W | Control read data |
| s_rvalid | output | 1 | Control read data valid |
| s_rready | input | 1 | Control read data ready |
| m_araddr | output | ADDR_W | Memory read burst address |
| m_arlen | output | 8 | Memory read burst length minus one |
| m_arvalid | output | 1 | Memory read address valid |
| m_arready | input | 1 | Memory read address ready |
| m_rdata | input | DATA_W | Memory read data |
| m_rvalid | input | 1 | Memory read data valid |
| m_rready | output | 1 | Memory read data ready |
| m_awaddr | output | ADDR_W | Memory write burst address |
| m_awlen | output | 8 | Memory write burst length minus one |
| m_awvalid | output | 1 | Memory write address valid |
| m_awready | input | 1 | Memory write address ready |
| m_wdata | output | DATA_W | Memory write data |
| m_wlast | output | 1 | Last beat of a write burst |
| m_wvalid | output | 1 | Memory write data valid |
| m_wready | input | 1 | Memory write data ready |
| m_bvalid | input | 1 | Memory write response valid |
| m_bready | output | 1 | Memory write response ready |

## Verification
The assertions assume that the memory side returns exactly arlen+1 read beats for each accepted read address. They also assume it sends one write response per burst, and only after the last write beat. The control master is assumed to hold its valid signals until they are accepted.

The bench memory model answers every address at once. It streams exactly the requested number of beats, with a periodic one-cycle gap in read data, and raises bvalid only after wlast. Its control tasks present address and data together and hold them until the slave is ready.

// File: rtl/incr_pkg.sv
package incr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ADDR,
        ST_RD_DATA,
        ST_COMPUTE,
        ST_WR_ADDR,
        ST_WR_DATA,
        ST_WR_RESP,
        ST_DONE
    } eng_state_e;

    // control register offsets and status bit positions
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_BASE  = 8'h10;
    localparam int         BIT_START = 0;
    localparam int         BIT_DONE  = 1;
    localparam int         BIT_IDLE  = 2;

endpackage

// File: rtl/incr_regs.sv
module incr_regs
    import incr_pkg::*;
#(
    parameter int CTRL_AW = 5,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CTRL_AW-1:0] s_awaddr,
    input  logic               s_awvalid,
    output logic               s_awready,
    input  logic [DATA_W-1:0]  s_wdata,
    input  logic               s_wvalid,
    output logic               s_wready,
    output logic               s_bvalid,
    input  logic               s_bready,
    input  logic [CTRL_AW-1:0] s_araddr,
    input  logic               s_arvalid,
    output logic               s_arready,
    output logic [DATA_W-1:0]  s_rdata,
    output logic               s_rvalid,
    input  logic               s_rready,
    output logic               start_o,
    output logic [DATA_W-1:0]  base_o,
    input  logic               eng_idle_i,
    input  logic               eng_done_i
);

    localparam logic [CTRL_AW-1:0] A_CTRL = CTRL_AW'(OFS_CTRL);
    localparam logic [CTRL_AW-1:0] A_BASE = CTRL_AW'(OFS_BASE);

    typedef struct packed {
        logic              start;
        logic              done;
        logic [DATA_W-1:0] base;
        logic              bvalid;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t reg_d, reg_q;
    logic  wr_fire, rd_fire;
    logic [DATA_W-1:0] ctrl_word;

    always_comb begin
        wr_fire   = s_awvalid && s_wvalid && !reg_q.bvalid;
        rd_fire   = s_arvalid && !reg_q.rvalid;
        ctrl_word = '0;
        ctrl_word[BIT_START] = reg_q.start;
        ctrl_word[BIT_DONE]  = reg_q.done;
        ctrl_word[BIT_IDLE]  = eng_idle_i;

        reg_d = reg_q;
        if (reg_q.bvalid && s_bready) reg_d.bvalid = 1'b0;
        if (reg_q.rvalid && s_rready) reg_d.rvalid = 1'b0;
        if (!eng_idle_i) reg_d.start = 1'b0;
        if (rd_fire) begin
            reg_d.rvalid = 1'b1;
            if (s_araddr == A_CTRL) begin
                reg_d.rdata = ctrl_word;
                reg_d.done  = 1'b0;
            end else if (s_araddr == A_BASE) begin
                reg_d.rdata = reg_q.base;
            end else begin
                reg_d.rdata = '0;
            end
        end
        if (wr_fire) begin
            reg_d.bvalid = 1'b1;
            if (s_awaddr == A_CTRL && s_wdata[BIT_START] && eng_idle_i)
                reg_d.start = 1'b1;
            if (s_awaddr == A_BASE)
                reg_d.base = s_wdata;
        end
        if (eng_done_i) reg_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign s_awready = wr_fire;
    assign s_wready  = wr_fire;
    assign s_bvalid  = reg_q.bvalid;
    assign s_arready = !reg_q.rvalid;
    assign s_rvalid  = reg_q.rvalid;
    assign s_rdata   = reg_q.rdata;
    assign start_o   = reg_q.start;
    assign base_o    = reg_q.base;

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_idle_i |=> !reg_q.start); // R3
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata)); // R1

endmodule

// File: rtl/incr_buf.sv
module incr_buf #(
    parameter int DEPTH  = 50,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/incr_engine.sv
module incr_engine
    import incr_pkg::*;
#(
    parameter int CTRL_AW   = 5,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 50,
    parameter int MAX_BURST = 16,
    parameter int ADDEND    = 100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CTRL_AW-1:0] s_awaddr,
    input  logic               s_awvalid,
    output logic               s_awready,
    input  logic [DATA_W-1:0]  s_wdata,
    input  logic               s_wvalid,
    output logic               s_wready,
    output logic               s_bvalid,
    input  logic               s_bready,
    input  logic [CTRL_AW-1:0] s_araddr,
    input  logic               s_arvalid,
    output logic               s_arready,
    output logic [DATA_W-1:0]  s_rdata,
    output logic               s_rvalid,
    input  logic               s_rready,
    output logic [ADDR_W-1:0]  m_araddr,
    output logic [7:0]         m_arlen,
    output logic               m_arvalid,
    input  logic               m_arready,
    input  logic [DATA_W-1:0]  m_rdata,
    input  logic               m_rvalid,
    output logic               m_rready,
    output logic [ADDR_W-1:0]  m_awaddr,
    output logic [7:0]         m_awlen,
    output logic               m_awvalid,
    input  logic               m_awready,
    output logic [DATA_W-1:0]  m_wdata,
    output logic               m_wlast,
    output logic               m_wvalid,
    input  logic               m_wready,
    input  logic               m_bvalid,
    output logic               m_bready
);

    localparam int IDX_W  = $clog2(NUM_WORDS + 1);
    localparam int BUF_AW = $clog2(NUM_WORDS);
    localparam int BEAT_W = $clog2(MAX_BURST);
    localparam int BSHIFT = $clog2(DATA_W / 8);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS);

    typedef struct packed {
        eng_state_e        st;
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  idx;
        logic [BEAT_W-1:0] beat;
        logic [BEAT_W-1:0] blen;
    } eng_t;

    eng_t eng_d, eng_q;

    logic              start;
    logic [DATA_W-1:0] base_reg;
    logic [IDX_W-1:0]  remaining;
    logic [BEAT_W-1:0] blen_calc;
    logic [ADDR_W-1:0] burst_addr;
    logic              buf_we;
    logic [DATA_W-1:0] buf_wdata, buf_rdata;
    logic [IDX_W-1:0]  idx_inc;

    incr_regs #(.CTRL_AW(CTRL_AW), .DATA_W(DATA_W)) i_regs (
        .clk, .rst_n,
        .s_awaddr, .s_awvalid, .s_awready, .s_wdata, .s_wvalid, .s_wready,
        .s_bvalid, .s_bready, .s_araddr, .s_arvalid, .s_arready,
        .s_rdata, .s_rvalid, .s_rready,
        .start_o    (start),
        .base_o     (base_reg),
        .eng_idle_i (eng_q.st == ST_IDLE),
        .eng_done_i (eng_q.st == ST_DONE)
    );

    incr_buf #(.DEPTH(NUM_WORDS), .DATA_W(DATA_W)) i_buf (
        .clk,
        .we    (buf_we),
        .waddr (BUF_AW'(eng_q.idx)),
        .wdata (buf_wdata),
        .raddr (BUF_AW'(eng_q.idx)),
        .rdata (buf_rdata)
    );

    always_comb begin
        remaining  = LAST_IDX - eng_q.idx;
        blen_calc  = (int'(remaining) > MAX_BURST) ? BEAT_W'(MAX_BURST - 1)
                                                   : BEAT_W'(remaining - IDX_W'(1));
        burst_addr = eng_q.base + (ADDR_W'(eng_q.idx) << BSHIFT);
        idx_inc    = eng_q.idx + IDX_W'(1);
        buf_we     = (eng_q.st == ST_RD_DATA && m_rvalid) || (eng_q.st == ST_COMPUTE);
        buf_wdata  = (eng_q.st == ST_COMPUTE) ? buf_rdata + DATA_W'(ADDEND) : m_rdata;

        eng_d = eng_q;
        unique case (eng_q.st)
            ST_IDLE: if (start) begin
                eng_d.base = ADDR_W'(base_reg);
                eng_d.idx  = '0;
                eng_d.st   = ST_RD_ADDR;
            end
            ST_RD_ADDR: if (m_arready) begin
                eng_d.blen = blen_calc;
                eng_d.beat = '0;
                eng_d.st   = ST_RD_DATA;
            end
            ST_RD_DATA: if (m_rvalid) begin
                eng_d.idx  = idx_inc;
                eng_d.beat = eng_q.beat + BEAT_W'(1);
                if (eng_q.beat == eng_q.blen) begin
                    if (idx_inc == LAST_IDX) begin
                        eng_d.idx = '0;
                        eng_d.st  = ST_COMPUTE;
                    end else begin
                        eng_d.st  = ST_RD_ADDR;
                    end
                end
            end
            ST_COMPUTE: begin
                eng_d.idx = idx_inc;
                if (idx_inc == LAST_IDX) begin
                    eng_d.idx = '0;
                    eng_d.st  = ST_WR_ADDR;
                end
            end
            ST_WR_ADDR: if (m_awready) begin
                eng_d.blen = blen_calc;
                eng_d.beat = '0;
                eng_d.st   = ST_WR_DATA;
            end
            ST_WR_DATA: if (m_wready) begin
                eng_d.idx  = idx_inc;
                eng_d.beat = eng_q.beat + BEAT_W'(1);
                if (eng_q.beat == eng_q.blen) eng_d.st = ST_WR_RESP;
            end
            ST_WR_RESP: if (m_bvalid) begin
                eng_d.st = (eng_q.idx == LAST_IDX) ? ST_DONE : ST_WR_ADDR;
            end
            ST_DONE: begin
                eng_d.idx = '0;
                eng_d.st  = ST_IDLE;
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{st: ST_IDLE, default: '0};
        else        eng_q <= eng_d;
    end

    assign m_araddr  = burst_addr;
    assign m_arlen   = 8'(blen_calc);
    assign m_arvalid = (eng_q.st == ST_RD_ADDR);
    assign m_rready  = (eng_q.st == ST_RD_DATA);
    assign m_awaddr  = burst_addr;
    assign m_awlen   = 8'(blen_calc);
    assign m_awvalid = (eng_q.st == ST_WR_ADDR);
    assign m_wdata   = buf_rdata;
    assign m_wvalid  = (eng_q.st == ST_WR_DATA);
    assign m_wlast   = m_wvalid && (eng_q.beat == eng_q.blen);
    assign m_bready  = (eng_q.st == ST_WR_RESP);

    AST_ARLEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid |-> int'(m_arlen) < MAX_BURST); // R6
    AST_AWLEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> int'(m_awlen) < MAX_BURST); // R6
    AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr) && $stable(m_arlen)); // R6
    AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata) && $stable(m_wlast)); // R4
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.idx <= LAST_IDX); // R4

endmodule

// File: tb/test_incr_engine.sv
module test_incr_engine;

    localparam int NW = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  s_awaddr = '0, s_araddr = '0;
    logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
    logic        s_bready = 1'b1, s_rready = 1'b1;
    logic [31:0] s_wdata = '0;
    logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [31:0] s_rdata;
    logic [31:0] m_araddr, m_awaddr, m_wdata;
    logic [7:0]  m_arlen, m_awlen;
    logic        m_arvalid, m_rready, m_awvalid, m_wlast, m_wvalid, m_bready;
    logic        m_arready = 1'b1, m_awready = 1'b1, m_wready = 1'b1;
    logic        m_rvalid = 1'b0, m_bvalid = 1'b0;
    logic [31:0] m_rdata = '0;

    always #5 clk = ~clk;

    incr_engine i_incr_engine (
        .clk, .rst_n,
        .s_awaddr, .s_awvalid, .s_awready, .s_wdata, .s_wvalid, .s_wready,
        .s_bvalid, .s_bready, .s_araddr, .s_arvalid, .s_arready,
        .s_rdata, .s_rvalid, .s_rready,
        .m_araddr, .m_arlen, .m_arvalid, .m_arready, .m_rdata, .m_rvalid, .m_rready,
        .m_awaddr, .m_awlen, .m_awvalid, .m_awready, .m_wdata, .m_wlast,
        .m_wvalid, .m_wready, .m_bvalid, .m_bready
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // memory model and burst recorder
    logic [31:0] mem [512];
    logic [31:0] rd_ptr, wr_ptr;
    int rd_left = 0, wr_beats = 0, gap = 0, rd_beats = 0;
    int ar_cnt = 0, aw_cnt = 0, bad_wlast = 0, rd_at_aw = -1;
    bit b_pend = 0;
    logic [31:0] ar_addr [8], aw_addr [8];
    int ar_len [8], aw_len [8], wb_len [8];

    initial begin
        forever begin
            @(negedge clk);
            gap++;
            if (rd_left > 0 && m_rready && (gap % 7 != 3)) begin
                m_rvalid = 1'b1;
                m_rdata  = mem[(rd_ptr >> 2) & 511];
                rd_ptr   = rd_ptr + 4;
                rd_left--;
                rd_beats++;
            end else begin
                m_rvalid = 1'b0;
            end
            if (m_arvalid) begin
                rd_ptr  = m_araddr;
                rd_left = int'(m_arlen) + 1;
                if (ar_cnt < 8) begin ar_addr[ar_cnt] = m_araddr; ar_len[ar_cnt] = int'(m_arlen) + 1; end
                ar_cnt++;
            end
            if (b_pend && m_bready) begin
                m_bvalid = 1'b1;
                b_pend   = 0;
            end else begin
                m_bvalid = 1'b0;
            end
            if (m_awvalid) begin
                wr_ptr = m_awaddr;
                if (aw_cnt == 0) rd_at_aw = rd_beats;
                if (aw_cnt < 8) begin aw_addr[aw_cnt] = m_awaddr; aw_len[aw_cnt] = int'(m_awlen) + 1; end
                aw_cnt++;
            end
            if (m_wvalid) begin
                mem[(wr_ptr >> 2) & 511] = m_wdata;
                wr_ptr = wr_ptr + 4;
                wr_beats++;
                if (m_wlast) begin
                    if (aw_cnt >= 1 && aw_cnt <= 8) begin
                        wb_len[aw_cnt-1] = wr_beats;
                        if (wr_beats != aw_len[aw_cnt-1]) bad_wlast++;
                    end
                    wr_beats = 0;
                    b_pend   = 1;
                end
            end
        end
    end

    task automatic ctl_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        s_awaddr = a; s_wdata = d; s_awvalid = 1'b1; s_wvalid = 1'b1;
        #1;
        while (!s_awready) begin @(negedge clk); #1; end
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        while (!s_bvalid) @(negedge clk);
    endtask

    task automatic ctl_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1'b1;
        #1;
        while (!s_arready) begin @(negedge clk); #1; end
        @(negedge clk);
        s_arvalid = 1'b0;
        while (!s_rvalid) @(negedge clk);
        d = s_rdata;
        @(negedge clk);
    endtask

    // vector table: base byte address, first value, step between words
    localparam logic [31:0] VEC_BASE [4] = '{32'h0000_0000, 32'h0000_0100, 32'h0000_0400, 32'h0000_0600};
    localparam logic [31:0] VEC_SEED [4] = '{32'h0000_0000, 32'h7FFF_FFE0, 32'hFFFF_FFC0, 32'h1234_5678};
    localparam logic [31:0] VEC_STEP [4] = '{32'h0000_0001, 32'h0000_0003, 32'h0000_0001, 32'h0101_0101};

    initial begin
        logic [31:0] rd;
        for (int i = 0; i < 512; i++) mem[i] = 32'hA5A5_0000 + 32'(i);
        repeat (3) @(negedge clk);
        check(!m_arvalid && !m_awvalid && !m_wvalid, "R2 master idle", {29'd0, m_arvalid, m_awvalid, m_wvalid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        ctl_read(5'h00, rd);
        check(rd == 32'h4, "R2 ctrl reset", rd, 32'h4);
        ctl_read(5'h10, rd);
        check(rd == 32'h0, "R2 base reset", rd, 32'h0);
        check(!m_arvalid && !m_awvalid && !m_wvalid, "R2 no master request", {29'd0, m_arvalid, m_awvalid, m_wvalid}, 0);
        ctl_write(5'h10, 32'hDEAD_BEE0);
        ctl_read(5'h10, rd);
        check(rd == 32'hDEAD_BEE0, "R1 base readback", rd, 32'hDEAD_BEE0);
        ctl_read(5'h08, rd);
        check(rd == 32'h0, "R1 unmapped offset", rd, 32'h0);

        for (int v = 0; v < 4; v++) begin
            int wb, errs, polls;
            logic [31:0] below, above, exp_w;
            wb = int'(VEC_BASE[v] >> 2);
            for (int k = 0; k < NW; k++) mem[(wb + k) & 511] = VEC_SEED[v] + VEC_STEP[v] * 32'(k);
            below = mem[(wb + 511) & 511];
            above = mem[(wb + NW) & 511];
            ar_cnt = 0; aw_cnt = 0; rd_beats = 0; rd_at_aw = -1; bad_wlast = 0;
            ctl_write(5'h10, VEC_BASE[v]);
            ctl_write(5'h00, 32'h1);
            repeat (4) @(negedge clk);
            ctl_read(5'h00, rd);
            check(rd[2:0] == 3'b000, "R3 busy: start cleared, idle low", rd, 0);
            ctl_write(5'h00, 32'h1); // R8: start while busy
            polls = 0;
            do begin ctl_read(5'h00, rd); polls++; end while (!rd[2] && polls < 500);
            check(rd[2:0] == 3'b110, "R7 done with idle", rd, 32'h6);
            ctl_read(5'h00, rd);
            check(rd[2:0] == 3'b100, "R7 done cleared on read", rd, 32'h4);
            repeat (30) @(negedge clk);
            errs = 0;
            for (int k = 0; k < NW; k++) begin
                exp_w = VEC_SEED[v] + VEC_STEP[v] * 32'(k) + 32'd100;
                if (mem[(wb + k) & 511] != exp_w) errs++;
            end
            check(errs == 0, "R4 words incremented", 32'(errs), 0);
            check(mem[(wb + 511) & 511] == below, "R4 word below untouched", mem[(wb + 511) & 511], below);
            check(mem[(wb + NW) & 511] == above, "R4 word above untouched", mem[(wb + NW) & 511], above);
            check(rd_at_aw == NW, "R5 reads complete before write", 32'(rd_at_aw), NW);
            check(ar_cnt == 4 && aw_cnt == 4, "R8 one pass of bursts", 32'(ar_cnt * 16 + aw_cnt), 32'h44);
            if (ar_cnt == 4 && aw_cnt == 4) begin
                for (int b = 0; b < 4; b++) begin
                    int el;
                    el = (b == 3) ? 2 : 16;
                    check(ar_len[b] == el && ar_addr[b] == VEC_BASE[v] + 32'(64 * b),
                          "R6 read burst", ar_addr[b] + 32'(ar_len[b]), VEC_BASE[v] + 32'(64 * b) + 32'(el));
                    check(aw_len[b] == el && aw_addr[b] == VEC_BASE[v] + 32'(64 * b) && wb_len[b] == el,
                          "R6 write burst", aw_addr[b] + 32'(wb_len[b]), VEC_BASE[v] + 32'(64 * b) + 32'(el));
                end
            end
            check(bad_wlast == 0, "R6 wlast position", 32'(bad_wlast), 0);
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog R4 actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule